// File: doc/BRIEF.md
# Two-wire slave write page buffer

This block is the receive side of a small serial memory sitting on a two-wire bus. It samples the bus clock and data lines with the system clock and recognises start and stop conditions. It frames bits into bytes, most significant bit first, and acknowledges each byte by pulling the data line low through an open-drain enable. The first byte after a start is the address/control byte: it is acknowledged but not kept. Every later byte is written into a circular page buffer. That buffer holds the most recent sixteen bytes of a burst of any length, so once it is full the oldest entry is overwritten.

When the stop condition arrives and at least one data byte was kept, the block presents the buffered bytes on a parallel commit port. The bytes come out oldest first, one per valid/ready handshake, together with the number of bytes held. The non-volatile array behind this port, read transfers and write-cycle timing belong to other blocks.

Top module: `i2c_page_slave`

## Requirements
- R1: After reset, `sda_oe` is 0 and `cm_valid` is 0.
- R2: A fall of SDA while SCL is high starts a transfer from idle. The first byte after a start is acknowledged and never appears on the commit port.
- R3: Bits are sampled on SCL high, MSB first. After eight data bits the block drives `sda_oe`=1 (SDA low) through the ninth SCL high period. `sda_oe` is 0 during the eight data-bit high periods and only rises while SCL is low.
- R4: A rise of SDA while SCL is high is a stop. If at least one data byte is held, `cm_valid` goes high, the bytes appear on `cm_data` oldest first, and `cm_count` equals the number of bytes held (1 to 16). `cm_count` stays constant through the commit.
- R5: A stop with no data byte received after the address byte produces no commit (`cm_valid` stays 0).
- R6: When more than 16 data bytes arrive, only the last 16 are committed, in arrival order, with `cm_count`=16. Exactly 16 bytes also commit with `cm_count`=16.
- R7: While `cm_valid`=1 and `cm_ready`=0, `cm_data` and `cm_count` hold. Each cycle with both high consumes one byte, and the commit ends after the last byte.
- R8: A stop or start that arrives before a byte's eighth bit has been followed by SCL low discards that partial byte.
- R9: A repeated start keeps the bytes already buffered. The byte after it is again an address byte that is not stored, and the next stop commits the bytes from both segments.
- R10: A start from idle after a finished commit begins with an empty buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| cm_valid | output | 1 | Commit byte available |
| cm_ready | input | 1 | Consumer accepts the current commit byte |
| cm_data | output | 8 | Commit byte, oldest first |
| cm_count | output | 5 | Number of bytes in this commit |

## Verification
The assertions assume that the bus lines hold each level for several system clocks. They also assume that SDA changes while SCL is high only to form a start or stop, and that `cm_ready` may take any value on any cycle. The stimulus holds every SCL phase for eight system clocks and changes the master's SDA only in the middle of SCL low, except for deliberate conditions. It models the wired-AND of master and slave on the data line, and drives `cm_ready` with an irregular stall pattern. All of this happens on the falling system clock edge, so the synchronisers never see two lines move in the same sampled cycle.

// File: rtl/i2c_page_slave.sv
module i2c_page_slave #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         scl_in,
  input  logic                         sda_in,
  output logic                         sda_oe,
  output logic                         cm_valid,
  input  logic                         cm_ready,
  output logic [DW-1:0]                cm_data,
  output logic [$clog2(DEPTH+1)-1:0]   cm_count
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = $clog2(DEPTH+1);
  localparam int BCW = $clog2(DW+1);

  typedef enum logic [1:0] {S_IDLE, S_BITS, S_ACK, S_OUT} st_t;

  logic [2:0] scl_p, sda_p;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
    end

  logic scl, scl_d, sda, sda_d;
  assign scl   = scl_p[1];
  assign scl_d = scl_p[2];
  assign sda   = sda_p[1];
  assign sda_d = sda_p[2];

  logic start_c, stop_c, rise, fall;
  assign start_c = scl & scl_d & sda_d & ~sda;
  assign stop_c  = scl & scl_d & ~sda_d & sda;
  assign rise    = scl & ~scl_d;
  assign fall    = ~scl & scl_d;

  st_t            st;
  logic [BCW-1:0] bitcnt;
  logic [DW-1:0]  shreg;
  logic           addr_phase;
  logic [AW-1:0]  wr_ptr, rd_ptr;
  logic [CW-1:0]  fill, left;
  logic           oe;
  logic [DW-1:0]  mem [DEPTH];

  logic byte_end, we;
  assign byte_end = (st == S_BITS) && !stop_c && !start_c && fall && (bitcnt == BCW'(DW));
  assign we       = byte_end && !addr_phase;

  always_ff @(posedge clk)
    if (we) mem[wr_ptr] <= shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st         <= S_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      addr_phase <= 1'b1;
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      fill       <= '0;
      left       <= '0;
      oe         <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (start_c) begin
            st         <= S_BITS;
            bitcnt     <= '0;
            addr_phase <= 1'b1;
            fill       <= '0;
            wr_ptr     <= '0;
          end
        S_BITS, S_ACK:
          if (stop_c) begin
            oe <= 1'b0;
            if (fill != '0) begin
              st     <= S_OUT;
              rd_ptr <= wr_ptr - AW'(fill);
              left   <= fill;
            end else begin
              st <= S_IDLE;
            end
          end else if (start_c) begin
            oe         <= 1'b0;
            st         <= S_BITS;
            bitcnt     <= '0;
            addr_phase <= 1'b1;
          end else if (st == S_BITS) begin
            if (rise && bitcnt != BCW'(DW)) begin
              shreg  <= {shreg[DW-2:0], sda};
              bitcnt <= bitcnt + BCW'(1);
            end else if (byte_end) begin
              st         <= S_ACK;
              oe         <= 1'b1;
              bitcnt     <= '0;
              addr_phase <= 1'b0;
              if (we) begin
                wr_ptr <= wr_ptr + AW'(1);
                if (fill != CW'(DEPTH)) fill <= fill + CW'(1);
              end
            end
          end else if (fall) begin
            oe <= 1'b0;
            st <= S_BITS;
          end
        S_OUT:
          if (cm_ready) begin
            rd_ptr <= rd_ptr + AW'(1);
            left   <= left - CW'(1);
            if (left == CW'(1)) begin
              st   <= S_IDLE;
              fill <= '0;
            end
          end
        default: st <= S_IDLE;
      endcase
    end

  assign sda_oe   = oe;
  assign cm_valid = (st == S_OUT);
  assign cm_data  = mem[rd_ptr];
  assign cm_count = fill;
endmodule

// File: rtl/i2c_page_slave_chk.sv
module i2c_page_slave_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       scl_sync,
  input logic                       sda_oe,
  input logic                       cm_valid,
  input logic                       cm_ready,
  input logic [DW-1:0]              cm_data,
  input logic [$clog2(DEPTH+1)-1:0] cm_count
);
  p_oe_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_sync)
    else $error("sda_oe rose while SCL high");

  p_count_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |-> (cm_count >= 1 && cm_count <= DEPTH))
    else $error("commit count out of range");

  p_count_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid && $past(cm_valid) |-> $stable(cm_count))
    else $error("commit count changed during commit");

  p_quiet_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |-> !sda_oe)
    else $error("ack drive during commit");

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid && !cm_ready |=> cm_valid && $stable(cm_data) && $stable(cm_count))
    else $error("commit byte not held under stall");
endmodule

bind i2c_page_slave i2c_page_slave_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_sync(scl_p[1]), .sda_oe(sda_oe),
  .cm_valid(cm_valid), .cm_ready(cm_ready), .cm_data(cm_data), .cm_count(cm_count)
);

// File: tb/test_i2c_page_slave.sv
`timescale 1ns/1ps
module test_i2c_page_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic cm_ready = 1'b0;
  logic sda_oe, cm_valid;
  logic [7:0] cm_data;
  logic [4:0] cm_count;
  wire sda_bus = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_page_slave i_i2c_page_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe),
    .cm_valid(cm_valid), .cm_ready(cm_ready), .cm_data(cm_data), .cm_count(cm_count)
  );

  int n_tests = 0, n_fail = 0;
  int cyc = 0, valid_cycles = 0, exp_cnt = 0;
  logic [7:0] pend[$];
  logic [7:0] exp_q[$];
  logic prev_stall = 1'b0;
  logic [7:0] prev_data;
  logic [4:0] prev_count;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hp(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) if (rst_n) begin
    cyc++;
    cm_ready = ((cyc * 7) % 5) != 0;
    if (prev_stall) begin
      chk(cm_valid == 1'b1, "R7 valid held under stall", cm_valid, 1);
      chk(cm_data == prev_data, "R7 data held under stall", cm_data, prev_data);
      chk(cm_count == prev_count, "R7 count held under stall", cm_count, prev_count);
    end
    prev_stall = cm_valid && !cm_ready;
    prev_data  = cm_data;
    prev_count = cm_count;
    if (cm_valid) begin
      valid_cycles++;
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected commit byte", cm_data, -1);
      else begin
        chk(cm_data == exp_q[0], "R4 commit byte order", cm_data, exp_q[0]);
        chk(cm_count == 5'(exp_cnt), "R4 commit count", cm_count, exp_cnt);
        if (cm_ready) void'(exp_q.pop_front());
      end
    end
  end

  task automatic bus_start(input bit fresh);
    sda_m = 1'b1; hp(4);
    scl_m = 1'b1; hp(8);
    sda_m = 1'b0; hp(8);
    scl_m = 1'b0; hp(4);
    if (fresh) pend.delete();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hp(4);
    scl_m = 1'b1; hp(8);
    if (pend.size() > 0) begin
      exp_cnt = (pend.size() > 16) ? 16 : pend.size();
      exp_q.delete();
      for (int i = pend.size() - exp_cnt; i < pend.size(); i++) exp_q.push_back(pend[i]);
    end
    pend.delete();
    sda_m = 1'b1; hp(8);
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; hp(4);
    scl_m = 1'b1; hp(4);
    chk(sda_oe == 1'b0, "R3 no drive during data bit", sda_oe, 0);
    hp(4);
    scl_m = 1'b0; hp(4);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit data);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; hp(4);
    scl_m = 1'b1; hp(4);
    chk(sda_oe == 1'b1, "R3 ack on ninth clock", sda_oe, 1);
    chk(sda_bus == 1'b0, "R3 SDA low during ack", sda_bus, 0);
    hp(4);
    scl_m = 1'b0; hp(4);
    if (data) pend.push_back(b);
  endtask

  task automatic send_partial(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) send_bit(b[i]);
  endtask

  task automatic wait_commit(input string req);
    int k = 0;
    while (exp_q.size() != 0 && k < 3000) begin hp(1); k++; end
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    hp(6);
    chk(cm_valid == 1'b0, req, cm_valid, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int vc;
    hp(5);
    chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
    chk(cm_valid == 1'b0, "R1 cm_valid after reset", cm_valid, 0);
    rst_n = 1'b1;
    hp(10);

    // R2 R3 R4: address byte dropped, MSB-first bytes committed in order
    bus_start(1'b1);
    send_byte(8'hA0, 1'b0);
    send_byte(8'h01, 1'b1);
    send_byte(8'h80, 1'b1);
    send_byte(8'h3C, 1'b1);
    bus_stop();
    wait_commit("R4 three-byte commit completes");

    // R5: address only, no commit
    vc = valid_cycles;
    bus_start(1'b1);
    send_byte(8'hA0, 1'b0);
    bus_stop();
    hp(200);
    chk(valid_cycles == vc, "R5 no commit without data", valid_cycles - vc, 0);

    // R6: 20 bytes keep last 16
    bus_start(1'b1);
    send_byte(8'hA2, 1'b0);
    for (int i = 0; i < 20; i++) send_byte(8'(i * 13 + 5), 1'b1);
    bus_stop();
    chk(exp_cnt == 16, "R6 model count", exp_cnt, 16);
    wait_commit("R6 overflow commit completes");

    // R6: exactly 16
    bus_start(1'b1);
    send_byte(8'hA0, 1'b0);
    for (int i = 0; i < 16; i++) send_byte(8'(255 - i * 9), 1'b1);
    bus_stop();
    wait_commit("R6 full commit completes");

    // R8: stop mid byte
    bus_start(1'b1);
    send_byte(8'hA0, 1'b0);
    send_byte(8'hC3, 1'b1);
    send_byte(8'h5E, 1'b1);
    send_partial(8'hFF, 5);
    bus_stop();
    wait_commit("R8 stop aborts partial byte");

    // R8 R9: repeated start mid byte keeps buffer
    bus_start(1'b1);
    send_byte(8'hA0, 1'b0);
    send_byte(8'h11, 1'b1);
    send_partial(8'h96, 5);
    bus_start(1'b0);
    send_byte(8'hA0, 1'b0);
    send_byte(8'h22, 1'b1);
    bus_stop();
    chk(exp_cnt == 2, "R9 model count across restart", exp_cnt, 2);
    wait_commit("R9 restart commit completes");

    // R10: new write starts empty
    bus_start(1'b1);
    send_byte(8'hA0, 1'b0);
    send_byte(8'h5A, 1'b1);
    bus_stop();
    chk(exp_cnt == 1, "R10 model count", exp_cnt, 1);
    wait_commit("R10 single-byte commit completes");

    // R6 R7: 17 bytes under stalls
    bus_start(1'b1);
    send_byte(8'hA0, 1'b0);
    for (int i = 0; i < 17; i++) send_byte(8'(i * 31 + 7), 1'b1);
    bus_stop();
    wait_commit("R7 stalled commit completes");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule